// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block decides when a logic-capture engine should start, pause and stop recording. It watches a sampled input vector through four ternary pattern triggers. Each trigger has a per-bit mask and value, so every input bit is required high, required low, or ignored. Two reloadable down-counters count trigger occurrences. An eight-level state machine moves up one level, or falls back to level 0, according to a per-level choice of event. Together these express conditions such as "the third match of pattern B after pattern A has been seen".

Host software writes the trigger patterns, the counter reload values and the selection tables, then pulses `arm`. From then on, every sample strobe evaluates the conditions against the current input. When the state machine reaches its last level it raises the stop strobe and disarms. The current level and both counter values can be read at any time. The capture memory is not part of this block.

Top module: `trig_sequencer`

## Requirements
- R1: Trigger t matches a sample when `((din ^ val_t) & mask_t) == 0`, where mask_t is `trig_mask[t*W +: W]` and val_t is `trig_val[t*W +: W]`. A mask bit of 0 makes that input bit a don't-care.
- R2: Event select codes (3 bits) are: 0..3 for trigger 0..3, 4 for counter 0 terminal, 5 for counter 1 terminal, 6 for never, 7 for every sample. At level L (0..LEVELS-2), the advance select is `adv_sel[L*3 +: 3]`. When the selected event occurs on an armed sample strobe, `level` increments in the following cycle. Without a sample strobe, the level does not change.
- R3: The reset select for level L is `rst_sel[L*3 +: 3]`. When this event occurs on an armed sample strobe, it takes priority over advance. It returns `level` to 0, pulses `cap_reset` for one cycle and reloads both counters.
- R4: Advancing into level LEVELS-1 pulses `cap_stop` for one cycle and clears `armed`. The level then holds at LEVELS-1.
- R5: A pulse on `arm` sets `armed`, sets `level` to 0, loads each counter from its reload value and clears `cap_pause`.
- R6: Counter k decrements on its decrement event (`cnt_dec_sel[k*3 +: 3]`: 0..3 for trigger, 4 for every sample, 5..7 for never). An event that finds the counter at 1 or 0 is the terminal event. The terminal event is usable in the same sample as select code 4+k, and it reloads the counter instead of decrementing it.
- R7: On each armed sample, `cap_start` pulses for one cycle when the event chosen by `start_sel` occurs. `cap_pause` takes the value of the event chosen by `pause_sel` and holds it until the next armed sample.
- R8: After reset, `level`, both counters, `armed` and all four strobes are 0.
- R9: Code 6 never fires and code 7 fires on every armed sample.
- R10: While not armed, sample strobes do not change `level` or either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arm pulse: level 0, counters reloaded |
| smp_en | input | 1 | Sample strobe; conditions are evaluated only here |
| din | input | W | Sampled input vector |
| trig_mask | input | 4*W | Per-trigger care mask |
| trig_val | input | 4*W | Per-trigger required bit values |
| cnt_reload | input | 2*W | Reload values of counters 0 and 1 |
| cnt_dec_sel | input | 6 | Decrement event select per counter |
| adv_sel | input | (LEVELS-1)*3 | Advance event select per level |
| rst_sel | input | (LEVELS-1)*3 | Reset event select per level |
| start_sel | input | 3 | Event driving the start strobe |
| pause_sel | input | 3 | Event driving the pause level |
| armed | output | 1 | Sequencer is running |
| level | output | $clog2(LEVELS) | Current sequencer level |
| cnt0 | output | W | Counter 0 current value |
| cnt1 | output | W | Counter 1 current value |
| cap_start | output | 1 | Start-capture strobe |
| cap_pause | output | 1 | Pause-capture level |
| cap_stop | output | 1 | Stop-capture strobe |
| cap_reset | output | 1 | Sequencer-reset strobe |

## Verification
A wrong level or counter value shows up on `level`, `cnt0` or `cnt1` in the cycle after the sample strobe that caused it. The bench therefore reads these outputs after every sample. A corrupted counter also delays or advances the terminal event, so the level step that depends on it lands on the wrong sample. A fault in the reset priority or in the final-level decode shows as a missing or extra strobe one cycle after the deciding sample. It can also show as `armed` staying high, which leaves later samples still moving the level.

// File: rtl/trig_sequencer.sv
module trig_sequencer #(
  parameter int W = 24,
  parameter int LEVELS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm,
  input  logic                       smp_en,
  input  logic [W-1:0]               din,
  input  logic [4*W-1:0]             trig_mask,
  input  logic [4*W-1:0]             trig_val,
  input  logic [2*W-1:0]             cnt_reload,
  input  logic [5:0]                 cnt_dec_sel,
  input  logic [(LEVELS-1)*3-1:0]    adv_sel,
  input  logic [(LEVELS-1)*3-1:0]    rst_sel,
  input  logic [2:0]                 start_sel,
  input  logic [2:0]                 pause_sel,
  output logic                       armed,
  output logic [$clog2(LEVELS)-1:0]  level,
  output logic [W-1:0]               cnt0,
  output logic [W-1:0]               cnt1,
  output logic                       cap_start,
  output logic                       cap_pause,
  output logic                       cap_stop,
  output logic                       cap_reset
);
  localparam int LW = $clog2(LEVELS);
  localparam logic [LW-1:0] PEN = LW'(LEVELS - 2);
  localparam logic [LW-1:0] LAST = LW'(LEVELS - 1);

  logic [3:0]   hit;
  logic [1:0]   dec_ev, tc;
  logic [W-1:0] cnt_q [2];
  logic [7:0]   evs;
  logic [LW-1:0] lvl_i;
  logic [2:0]   sel_a, sel_r;
  logic         live, seq_rst, seq_adv;

  assign live = armed & smp_en & ~arm;

  for (genvar t = 0; t < 4; t++) begin : g_trig
    assign hit[t] = ((din ^ trig_val[t*W +: W]) & trig_mask[t*W +: W]) == '0;
  end

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    logic [2:0] ds;
    assign ds = cnt_dec_sel[k*3 +: 3];
    assign dec_ev[k] = live & (ds[2] ? (ds[1:0] == 2'd0) : hit[ds[1:0]]);
    assign tc[k] = dec_ev[k] & (cnt_q[k] <= W'(1));
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[k] <= '0;
      else if (arm || seq_rst || tc[k]) cnt_q[k] <= cnt_reload[k*W +: W];
      else if (dec_ev[k]) cnt_q[k] <= cnt_q[k] - W'(1);
    end
  end

  assign cnt0 = cnt_q[0];
  assign cnt1 = cnt_q[1];
  assign evs = {1'b1, 1'b0, tc, hit};
  assign lvl_i = (level == LAST) ? '0 : level;
  assign sel_a = adv_sel[lvl_i*3 +: 3];
  assign sel_r = rst_sel[lvl_i*3 +: 3];
  assign seq_rst = live & evs[sel_r];
  assign seq_adv = live & ~seq_rst & evs[sel_a];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      level <= '0;
      cap_start <= 1'b0;
      cap_pause <= 1'b0;
      cap_stop <= 1'b0;
      cap_reset <= 1'b0;
    end else begin
      cap_start <= 1'b0;
      cap_stop <= 1'b0;
      cap_reset <= 1'b0;
      if (arm) begin
        armed <= 1'b1;
        level <= '0;
        cap_pause <= 1'b0;
      end else if (live) begin
        cap_start <= evs[start_sel];
        cap_pause <= evs[pause_sel];
        if (seq_rst) begin
          level <= '0;
          cap_reset <= 1'b1;
        end else if (seq_adv) begin
          level <= level + LW'(1);
          if (level == PEN) begin
            cap_stop <= 1'b1;
            armed <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/trig_sequencer_chk.sv
module trig_sequencer_chk #(
  parameter int W = 24,
  parameter int LEVELS = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      arm,
  input logic                      smp_en,
  input logic                      armed,
  input logic [$clog2(LEVELS)-1:0] level,
  input logic [W-1:0]              cnt0,
  input logic [W-1:0]              cnt1,
  input logic                      cap_stop,
  input logic                      cap_reset
);
  localparam int LW = $clog2(LEVELS);

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en && !arm |=> $stable(level)); // R2
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    armed && smp_en && !arm |=> level == '0 || level == $past(level) || level == $past(level) + LW'(1)); // R2
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cap_reset |-> level == '0); // R3
  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stop |=> !cap_stop); // R4
  AST_STOP_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stop |-> !armed && level == LW'(LEVELS - 1)); // R4
  AST_ARM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> armed && level == '0); // R5
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !arm |=> $stable(level) && $stable(cnt0) && $stable(cnt1)); // R10
endmodule

bind trig_sequencer trig_sequencer_chk #(.W(W), .LEVELS(LEVELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .smp_en(smp_en), .armed(armed),
  .level(level), .cnt0(cnt0), .cnt1(cnt1), .cap_stop(cap_stop), .cap_reset(cap_reset)
);

// File: tb/sim_trig_sequencer.sv
module sim_trig_sequencer;
  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, smp_en = 1'b0;
  logic [23:0] din = '0;
  logic [95:0] trig_mask = '0, trig_val = '0;
  logic [47:0] cnt_reload = '0;
  logic [5:0]  cnt_dec_sel = 6'o66;
  logic [20:0] adv_sel = {7{3'd6}}, rst_sel = {7{3'd6}};
  logic [2:0]  start_sel = 3'd6, pause_sel = 3'd6;
  logic armed, cap_start, cap_pause, cap_stop, cap_reset;
  logic [2:0] level;
  logic [23:0] cnt0, cnt1;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  trig_sequencer u0 (.*);

  // mask, val, din, expected match
  localparam logic [72:0] VEC [6] = '{
    {24'h000000, 24'h000000, 24'hABCDEF, 1'b1},
    {24'hFFFFFF, 24'h123456, 24'h123456, 1'b1},
    {24'hFFFFFF, 24'h123456, 24'h123457, 1'b0},
    {24'h0000F0, 24'h000050, 24'h9AB05C, 1'b1},
    {24'h800000, 24'h800000, 24'h7FFFFF, 1'b0},
    {24'h000001, 24'h000000, 24'hFFFFFE, 1'b1}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic do_arm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic sample(input logic [23:0] d);
    @(negedge clk) begin din = d; smp_en = 1'b1; end
    @(negedge clk) smp_en = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 level", level, 0);
    chk("R8 armed", armed, 0);
    chk("R8 cnt0", cnt0, 0);
    chk("R8 strobes", {cap_start, cap_pause, cap_stop, cap_reset}, 0);

    adv_sel = {7{3'd7}};
    cnt_dec_sel = 6'o44;
    sample(24'h1);
    chk("R10 level unarmed", level, 0);
    chk("R10 cnt1 unarmed", cnt1, 0);

    adv_sel = {{6{3'd6}}, 3'd0};
    cnt_dec_sel = 6'o66;
    for (int i = 0; i < 6; i++) begin
      trig_mask[23:0] = VEC[i][72:49];
      trig_val[23:0]  = VEC[i][48:25];
      do_arm();
      sample(VEC[i][24:1]);
      chk($sformatf("R1 vector %0d", i), level, {2'b0, VEC[i][0]});
    end

    cnt_reload = {24'd9, 24'd3};
    cnt_dec_sel = 6'o64;
    adv_sel = {{6{3'd6}}, 3'd4};
    do_arm();
    chk("R5 cnt0 loaded", cnt0, 3);
    chk("R5 cnt1 loaded", cnt1, 9);
    sample(24'h0);
    chk("R6 cnt0 dec", cnt0, 2);
    chk("R2 no advance", level, 0);
    sample(24'h0);
    chk("R6 cnt0 dec2", cnt0, 1);
    sample(24'h0);
    chk("R6 terminal advance", level, 1);
    chk("R6 terminal reload", cnt0, 3);
    chk("R6 cnt1 never", cnt1, 9);

    adv_sel = {{6{3'd6}}, 3'd7};
    rst_sel = {{6{3'd6}}, 3'd7};
    do_arm();
    sample(24'h0);
    chk("R3 priority level", level, 0);
    chk("R3 cap_reset", cap_reset, 1);
    chk("R3 counter reload", cnt0, 3);
    @(negedge clk);
    chk("R3 cap_reset pulse", cap_reset, 0);

    trig_mask[23:0] = '0;
    rst_sel = {{5{3'd6}}, 3'd0, 3'd6};
    do_arm();
    sample(24'h0);
    chk("R2 advance to 1", level, 1);
    sample(24'h0);
    chk("R3 reset from level 1", level, 0);
    chk("R3 reset strobe level 1", cap_reset, 1);

    adv_sel = {7{3'd6}};
    rst_sel = {7{3'd6}};
    cnt_dec_sel = 6'o66;
    do_arm();
    sample(24'h0);
    chk("R9 never code", {level, cap_reset}, 0);

    adv_sel = {7{3'd7}};
    do_arm();
    for (int i = 0; i < 6; i++) sample(24'h0);
    chk("R9 always code", level, 6);
    chk("R4 no early stop", cap_stop, 0);
    sample(24'h0);
    chk("R4 final level", level, 7);
    chk("R4 cap_stop", cap_stop, 1);
    chk("R4 disarm", armed, 0);
    @(negedge clk);
    chk("R4 stop pulse", cap_stop, 0);
    cnt_dec_sel = 6'o44;
    sample(24'h0);
    chk("R10 level after stop", level, 7);
    chk("R10 cnt0 after stop", cnt0, 3);

    do_arm();
    chk("R5 rearm level", level, 0);
    chk("R5 rearm armed", armed, 1);

    cnt_dec_sel = 6'o66;
    adv_sel = {7{3'd6}};
    trig_mask[47:0] = {24'hFF, 24'hFF};
    trig_val[47:0]  = {24'h22, 24'h11};
    start_sel = 3'd0;
    pause_sel = 3'd1;
    sample(24'h11);
    chk("R7 start", {cap_start, cap_pause}, 2'b10);
    @(negedge clk);
    chk("R7 start pulse", cap_start, 0);
    sample(24'h22);
    chk("R7 pause", {cap_start, cap_pause}, 2'b01);
    repeat (2) @(negedge clk);
    chk("R7 pause held", cap_pause, 1);
    sample(24'h33);
    chk("R7 pause drop", cap_pause, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule